// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in physical memory. A core hands it a virtual address and an access kind (read or write). The walker reads a first-level entry, then, if that entry points to a second-level table, reads the second-level entry. It either returns the physical address or reports why the access cannot go ahead. The fault codes separate three cases. An address outside the process's mapping is one case. A page that is mapped but currently swapped out is another. A write to a read-only page is the third.

The walker keeps a root register that holds the page number of the first-level table. Privileged software reloads it on a context switch to select another address space. A write issued without the kernel flag leaves the register unchanged. The memory side is a plain read port with one read in flight at a time. The request side is a valid/ready handshake with a one-cycle response pulse.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to address {root page number, va[31:22], 2'b00}, where the root page number is bits [31:12] of the last accepted root write.
- R2: When the first-level entry has bit 0 set, the second read goes to {first-level entry[31:12], va[21:12], 2'b00}.
- R3: A second-level entry with bit 2 (mapped) and bit 0 (resident) set, and either a read access or bit 1 (writable) set, gives code 0 with rsp_fault low. In that case rsp_paddr = {entry[31:12], va[11:0]}, and the walk makes exactly two memory reads.
- R4: A first-level entry with bit 0 clear gives rsp_fault high with code 1 (invalid) after a single memory read.
- R5: A second-level entry with bit 2 clear gives rsp_fault high with code 1 (invalid).
- R6: A second-level entry with bit 2 set and bit 0 clear gives code 2 (not resident), for both reads and writes.
- R7: A write to a resident, mapped page whose bit 1 is clear gives code 3 (protection). A read of the same page succeeds.
- R8: Every response returns the request's virtual address on rsp_vaddr, and rsp_paddr is zero on a fault.
- R9: rsp_valid is high for exactly one cycle per accepted request. req_ready is high only while no walk is in progress.
- R10: A root write with root_wr_kernel low has no effect on later walks. A kernel root write switches later walks to the new table.
- R11: mem_req is a one-cycle pulse, and no new read is issued before mem_rvalid returns the previous one. The walker accepts any read latency.
- R12: After reset the walker is idle with req_ready high, rsp_valid and mem_req low, and a root page number of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_wr_en | input | 1 | Root register write strobe |
| root_wr_kernel | input | 1 | Write issued in privileged mode |
| root_wr_data | input | 32 | New root address; bits [31:12] are kept |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 2 | 0 ok, 1 invalid, 2 not resident, 3 protection |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_vaddr | output | 32 | Virtual address of the answered request |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (table entry) |

## Verification
Walks are tried against a small hand-built table set. One address uses the highest index at both levels, so a slip in the index fields shows up there. Separate addresses have a null first-level entry, an unmapped second-level entry, a swapped-out page and a read-only page. This pulls apart the three fault codes and the early stop after one read. The same read-only page is read and then written, which shows that the access kind alone changes the result. Root writes made with and without the kernel flag are followed by the same virtual address: an ignored write leaves the old translation, and an accepted one gives a different physical address. Memory latency is varied from zero to three wait cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int IDX_W = 10;
  localparam int OFF_W = 12;
  localparam int VA_W  = 2 * IDX_W + OFF_W;
  localparam int PTE_W = 32;
  localparam int PPN_W = PTE_W - OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int ENT_SHIFT = 2;

  localparam int BIT_RES = 0;
  localparam int BIT_WR  = 1;
  localparam int BIT_MAP = 2;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_ABSENT  = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_WT1, ST_RD2, ST_WT2, ST_DONE, ST_FAULT
  } walk_st_e;

  function automatic logic [IDX_W-1:0] hi_index(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] lo_index(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic logic [PA_W-1:0] lvl1_addr(input logic [PPN_W-1:0] root,
                                                input logic [VA_W-1:0] va);
    return {root, hi_index(va), {ENT_SHIFT{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] lvl2_addr(input logic [PTE_W-1:0] pte1,
                                                input logic [VA_W-1:0] va);
    return {pte1[PTE_W-1 -: PPN_W], lo_index(va), {ENT_SHIFT{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PTE_W-1:0] pte2,
                                              input logic [VA_W-1:0] va);
    return {pte2[PTE_W-1 -: PPN_W], va[OFF_W-1:0]};
  endfunction

  function automatic fault_e judge(input logic [PTE_W-1:0] pte2, input logic is_wr);
    if (!pte2[BIT_MAP])               return FLT_INVALID;
    else if (!pte2[BIT_RES])          return FLT_ABSENT;
    else if (is_wr && !pte2[BIT_WR])  return FLT_PROT;
    else                              return FLT_NONE;
  endfunction
endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_kernel,
  input  logic [PA_W-1:0]  wr_data,
  output logic [PPN_W-1:0] root_ppn
);
  logic take_wr;
  assign take_wr = wr_en && wr_kernel;

  always_ff @(posedge clk) begin
    if (!rst_n)       root_ppn <= '0;
    else if (take_wr) root_ppn <= wr_data[PA_W-1 -: PPN_W];
  end

  // R10
  user_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_wr |=> $stable(root_ppn));
endmodule

// File: rtl/ptw_pte_judge.sv
module ptw_pte_judge
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte2,
  input  logic             is_wr,
  input  logic [VA_W-1:0]  va,
  output fault_e           code,
  output logic [PA_W-1:0]  pa
);
  always_comb begin
    code = judge(pte2, is_wr);
    pa   = (code == FLT_NONE) ? join_pa(pte2, va) : '0;
  end
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  input  fault_e           l2_code,
  input  logic [PA_W-1:0]  l2_pa,
  output logic [VA_W-1:0]  va_q,
  output logic             wr_q,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output fault_e           rsp_code,
  output logic [PA_W-1:0]  rsp_paddr
);
  walk_st_e         st, st_nx;
  logic [PPN_W-1:0] root_q;
  logic [PTE_W-1:0] l1_q;

  logic walk_accept, l1_absent, l1_present, l2_back;
  assign walk_accept = req_valid && req_ready;
  assign l1_absent   = (st == ST_WT1) && mem_rvalid && !mem_rdata[BIT_RES];
  assign l1_present  = (st == ST_WT1) && mem_rvalid &&  mem_rdata[BIT_RES];
  assign l2_back     = (st == ST_WT2) && mem_rvalid;

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_RD1) || (st == ST_RD2);
  assign mem_addr  = (st == ST_RD2) ? lvl2_addr(l1_q, va_q) : lvl1_addr(root_q, va_q);
  assign rsp_valid = (st == ST_DONE) || (st == ST_FAULT);
  assign rsp_fault = (st == ST_FAULT);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (walk_accept) st_nx = ST_RD1;
      ST_RD1:   st_nx = ST_WT1;
      ST_WT1:   if (l1_absent) st_nx = ST_FAULT;
                else if (l1_present) st_nx = ST_RD2;
      ST_RD2:   st_nx = ST_WT2;
      ST_WT2:   if (l2_back) st_nx = (l2_code == FLT_NONE) ? ST_DONE : ST_FAULT;
      ST_DONE:  st_nx = ST_IDLE;
      ST_FAULT: st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      root_q    <= '0;
      l1_q      <= '0;
      va_q      <= '0;
      wr_q      <= 1'b0;
      rsp_code  <= FLT_NONE;
      rsp_paddr <= '0;
    end else begin
      st <= st_nx;
      if (walk_accept) begin
        va_q   <= req_vaddr;
        wr_q   <= req_write;
        root_q <= root_ppn;
      end
      if (l1_present) l1_q <= mem_rdata;
      if (l1_absent) begin
        rsp_code  <= FLT_INVALID;
        rsp_paddr <= '0;
      end
      if (l2_back) begin
        rsp_code  <= l2_code;
        rsp_paddr <= l2_pa;
      end
    end
  end

  // R9
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> !req_ready);
  // R11
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R4
  l1_null_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_absent |=> (rsp_fault && rsp_code == FLT_INVALID && !mem_req));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        root_wr_en,
  input  logic        root_wr_kernel,
  input  logic [31:0] root_wr_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [1:0]  rsp_code,
  output logic [31:0] rsp_paddr,
  output logic [31:0] rsp_vaddr,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  logic [PPN_W-1:0] root_ppn;
  fault_e           l2_code, code_q;
  logic [PA_W-1:0]  l2_pa;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;

  ptw_root_reg u_root (
    .clk(clk), .rst_n(rst_n), .wr_en(root_wr_en), .wr_kernel(root_wr_kernel),
    .wr_data(root_wr_data), .root_ppn(root_ppn)
  );

  ptw_pte_judge u_judge (
    .pte2(mem_rdata), .is_wr(wr_q), .va(va_q), .code(l2_code), .pa(l2_pa)
  );

  ptw_walk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .l2_code(l2_code),
    .l2_pa(l2_pa), .va_q(va_q), .wr_q(wr_q), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_code(code_q), .rsp_paddr(rsp_paddr)
  );

  assign rsp_code  = code_q;
  assign rsp_vaddr = va_q;

  // R3
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]);
  // R8
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic root_wr_en = 0, root_wr_kernel = 0;
  logic [31:0] root_wr_data = '0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault, mem_req;
  logic [1:0] rsp_code;
  logic [31:0] rsp_paddr, rsp_vaddr, mem_addr;
  logic mem_rvalid = 0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, failures = 0;
  int lat = 0, reads = 0;
  int unsigned root_pg = 0;
  logic [31:0] mem [int unsigned];
  int unsigned exp_addr [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input int unsigned a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory read port model
  initial begin
    forever begin
      @(negedge clk);
      while (rst_n && mem_req) begin
        reads++;
        if (exp_addr.size() == 0) check(0, "R11 unexpected read", mem_addr, 0);
        else begin
          int unsigned e;
          e = exp_addr.pop_front();
          check(mem_addr == e, "R1/R2 read address", mem_addr, e);
        end
        begin
          int unsigned a;
          a = mem_addr;
          @(negedge clk);
          check(!mem_req, "R11 second read while busy", {31'b0, mem_req}, 0);
          for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check(!mem_req, "R11 second read while busy", {31'b0, mem_req}, 0);
          end
          mem_rvalid = 1'b1;
          mem_rdata  = rd(a);
          @(negedge clk);
          mem_rvalid = 1'b0;
          mem_rdata  = '0;
        end
      end
    end
  end

  task automatic root_write(input logic [31:0] d, input logic kern);
    @(negedge clk);
    root_wr_en = 1; root_wr_kernel = kern; root_wr_data = d;
    @(negedge clk);
    root_wr_en = 0; root_wr_kernel = 0;
    if (kern) root_pg = d >> 12;
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input string req);
    int unsigned a1, a2, e1, e2, ecode, epa, nreads;
    bit seen;
    a1 = root_pg * 4096 + (va >> 22) * 4;
    e1 = rd(a1);
    exp_addr.push_back(a1);
    nreads = 1; epa = 0;
    if ((e1 & 1) == 0) ecode = 1;
    else begin
      a2 = (e1 & 32'hFFFF_F000) + ((va >> 12) & 1023) * 4;
      e2 = rd(a2);
      exp_addr.push_back(a2);
      nreads = 2;
      if ((e2 & 4) == 0) ecode = 1;
      else if ((e2 & 1) == 0) ecode = 2;
      else if (wr && (e2 & 2) == 0) ecode = 3;
      else begin ecode = 0; epa = (e2 & 32'hFFFF_F000) | (va & 32'hFFF); end
    end
    reads = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, {req, " R9 ready while busy"}, {31'b0, req_ready}, 0);
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (rsp_valid) seen = 1;
    end
    check(seen, {req, " R9 response missing"}, 0, 1);
    if (seen) begin
      check(rsp_code == ecode[1:0], {req, " code"}, rsp_code, ecode);
      check(rsp_fault == (ecode != 0), {req, " fault flag"}, rsp_fault, ecode != 0);
      check(rsp_paddr == epa, {req, " paddr"}, rsp_paddr, epa);
      check(rsp_vaddr == va, {req, " R8 vaddr"}, rsp_vaddr, va);
      @(negedge clk);
      check(!rsp_valid, {req, " R9 pulse width"}, {31'b0, rsp_valid}, 0);
      check(req_ready, {req, " R9 ready after"}, {31'b0, req_ready}, 1);
    end
    check(reads == nreads, {req, " read count"}, reads, nreads);
    exp_addr.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // tables: root page 0, second-level table at page 5 and page 7
    mem[32'h0004] = 32'h0000_5001;
    mem[32'h0008] = 32'h0000_0000;
    mem[32'h0FFC] = 32'h0000_7001;
    mem[32'h5004] = 32'h0012_3007;
    mem[32'h5008] = 32'h0004_4005;
    mem[32'h500C] = 32'h0000_0004;
    mem[32'h5010] = 32'h0000_0000;
    mem[32'h7FFC] = 32'hABCD_E007;
    // alternate space at root page 9
    mem[32'h9004] = 32'h0000_A001;
    mem[32'hA004] = 32'h0055_5007;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready, "R12 ready after reset", {31'b0, req_ready}, 1);
    check(!rsp_valid, "R12 no response after reset", {31'b0, rsp_valid}, 0);
    check(!mem_req, "R12 no read after reset", {31'b0, mem_req}, 0);

    lat = 0; walk(32'h0040_1234, 0, "R3 R12 read ok root 0");
    lat = 2; walk(32'h0040_1234, 1, "R3 write ok");
    lat = 1; walk(32'hFFFF_FFFF, 0, "R1 R2 top indices");
    lat = 3; walk(32'h0080_0010, 0, "R4 null level1");
    lat = 0; walk(32'h0040_4ABC, 1, "R5 unmapped level2");
    lat = 1; walk(32'h0040_3001, 0, "R6 absent read");
    lat = 2; walk(32'h0040_3001, 1, "R6 absent write");
    lat = 0; walk(32'h0040_2FFF, 0, "R7 readonly read");
    lat = 1; walk(32'h0040_2FFF, 1, "R7 readonly write");
    lat = 0;
    root_write(32'h0000_9000, 0);
    walk(32'h0040_1234, 0, "R10 user root write ignored");
    root_write(32'h0000_9ABC, 1);
    walk(32'h0040_1234, 0, "R10 kernel root switch");
    lat = 3; walk(32'h0040_1000, 1, "R10 R11 new space slow memory");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule